// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for each architectural floating-point register, its committed value and the tag of the reservation station that will produce its next value. Tag zero means no producer is outstanding. When an instruction issues, two source lookups return either a usable value or the producer tag the station must wait for. In the same cycle the destination register is claimed by the issuing station's tag.

Results come back over a broadcast bus carrying a station tag and data. A register accepts the data only when its pending tag equals the broadcast tag, and that pending tag then drops to zero. A newer issue to the same register replaces the tag, so the broadcast of an older producer lands nowhere and the WAW stall goes away. The reservation stations and the bus arbiter are outside this block; issue and broadcast come in as plain ports.

Top module: `rename_status_table`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears every pending tag and every register value to zero.
- R2: A source lookup of a register with no pending writer (tag 0) returns tag 0 and the register's committed value.
- R3: A source lookup of a register with a pending writer returns that writer's tag.
- R4: An issue (`iss_valid`=1, nonzero `iss_tag`) makes `iss_tag` the pending tag of `iss_dst` from the next cycle on.
- R5: A second issue to a register that is already pending replaces the tag. A later broadcast of the replaced, older tag changes neither the value nor the tag of that register.
- R6: A broadcast whose tag equals a register's pending tag writes `bc_data` into that register and clears its tag to 0. Both take effect on the next cycle.
- R7: If a new issue targets a register in the same cycle that a broadcast matches its old tag, the register takes the new tag and still stores the broadcast data.
- R8: Lookups are bypassed. When a same-cycle valid broadcast matches the tag a source would return, the lookup returns tag 0 and `bc_data` combinationally.
- R9: A source that names the register being issued to in the same cycle returns the mapping from before that issue.
- R10: Tag value 0 is reserved. An issue or a broadcast carrying tag 0 changes no tag and no value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue strobe |
| iss_dst | input | IW | Destination register of the issuing instruction |
| iss_tag | input | TW | Tag of the receiving station (nonzero) |
| src_a | input | IW | First source register index |
| src_b | input | IW | Second source register index |
| src_a_tag | output | TW | Producer tag for source A, 0 when the value is ready |
| src_a_val | output | DW | Value for source A |
| src_b_tag | output | TW | Producer tag for source B, 0 when the value is ready |
| src_b_val | output | DW | Value for source B |
| bc_valid | input | 1 | Result broadcast strobe |
| bc_tag | input | TW | Tag of the producing station |
| bc_data | input | DW | Broadcast result data |

## Verification
The source lookups are combinational. Each check is made in the same cycle as its inputs, before the clock edge. That is how the bypass cases (R8, R9) are seen. Issue and broadcast updates land at the next rising edge, so their effect is checked through a lookup in the following vector. Each table row therefore reads state written by earlier rows, and the expected values follow that chain one cycle at a time.

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NREG = 16,
  parameter int TW   = 4,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [IW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  output logic [TW-1:0] src_a_tag,
  output logic [DW-1:0] src_a_val,
  output logic [TW-1:0] src_b_tag,
  output logic [DW-1:0] src_b_val,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data
);

  logic [NREG-1:0][TW-1:0] tag_q;
  logic [NREG-1:0][DW-1:0] val_q;

  wire iss_go = iss_valid && (iss_tag != '0);
  wire bc_go  = bc_valid && (bc_tag != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bc_go && tag_q[r] == bc_tag) val_q[r] <= bc_data;
        if (iss_go && iss_dst == IW'(r))
          tag_q[r] <= iss_tag;
        else if (bc_go && tag_q[r] == bc_tag)
          tag_q[r] <= '0;
      end
    end
  end

  wire [TW-1:0] a_raw = tag_q[src_a];
  wire [TW-1:0] b_raw = tag_q[src_b];
  wire a_byp = bc_go && (a_raw == bc_tag);
  wire b_byp = bc_go && (b_raw == bc_tag);

  assign src_a_tag = a_byp ? '0 : a_raw;
  assign src_a_val = a_byp ? bc_data : val_q[src_a];
  assign src_b_tag = b_byp ? '0 : b_raw;
  assign src_b_val = b_byp ? bc_data : val_q[src_b];

endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
  parameter int NREG = 16,
  parameter int TW   = 4,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss_valid,
  input logic [IW-1:0]           iss_dst,
  input logic [TW-1:0]           iss_tag,
  input logic [TW-1:0]           src_a_tag,
  input logic [TW-1:0]           src_b_tag,
  input logic                    bc_valid,
  input logic [TW-1:0]           bc_tag,
  input logic [DW-1:0]           bc_data,
  input logic [NREG-1:0][TW-1:0] tag_q,
  input logic [NREG-1:0][DW-1:0] val_q
);

  // R4
  issue_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_tag != '0) |=> tag_q[$past(iss_dst)] == $past(iss_tag));

  // R8
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != '0) |-> src_a_tag != bc_tag);

  // R8
  bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != '0) |-> src_b_tag != bc_tag);

  // R10
  null_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_tag == '0 && !bc_valid) |=> tag_q == $past(tag_q));

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    // R6
    bc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && bc_tag != '0 && tag_q[r] == bc_tag) |=> val_q[r] == $past(bc_data));
    // R6
    bc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && bc_tag != '0 && tag_q[r] == bc_tag &&
       !(iss_valid && iss_tag != '0 && iss_dst == IW'(r))) |=> tag_q[r] == '0);
    // R5
    stale_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bc_valid && bc_tag != '0 && tag_q[r] == bc_tag) |=> $stable(val_q[r]));
  end

endmodule

bind rename_status_table rename_status_table_chk #(.NREG(NREG), .TW(TW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
  .src_a_tag(src_a_tag), .src_b_tag(src_b_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
  .bc_data(bc_data), .tag_q(tag_q), .val_q(val_q)
);

// File: tb/rename_status_table_tb.sv
`timescale 1ns/1ps
module rename_status_table_tb;
  localparam int NV = 15;

  typedef struct packed {
    logic        iv;
    logic [3:0]  dst;
    logic [3:0]  itag;
    logic [3:0]  sa;
    logic [3:0]  sb;
    logic        bv;
    logic [3:0]  btag;
    logic [31:0] bdata;
    logic [3:0]  ea_tag;
    logic [31:0] ea_val;
    logic [3:0]  eb_tag;
    logic [31:0] eb_val;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd2,  4'd1,  4'd2,  4'd3, 1'b0, 4'd0,  32'h0,        4'd0, 32'h0,        4'd0, 32'h0},
    '{1'b1, 4'd3,  4'd2,  4'd2,  4'd5, 1'b0, 4'd0,  32'h0,        4'd1, 32'h0,        4'd0, 32'h0},
    '{1'b0, 4'd0,  4'd0,  4'd2,  4'd3, 1'b1, 4'd1,  32'h11,       4'd0, 32'h11,       4'd2, 32'h0},
    '{1'b0, 4'd0,  4'd0,  4'd2,  4'd3, 1'b0, 4'd0,  32'h0,        4'd0, 32'h11,       4'd2, 32'h0},
    '{1'b1, 4'd3,  4'd5,  4'd3,  4'd3, 1'b0, 4'd0,  32'h0,        4'd2, 32'h0,        4'd2, 32'h0},
    '{1'b0, 4'd0,  4'd0,  4'd3,  4'd2, 1'b1, 4'd2,  32'h22,       4'd5, 32'h0,        4'd0, 32'h11},
    '{1'b0, 4'd0,  4'd0,  4'd3,  4'd4, 1'b0, 4'd0,  32'h0,        4'd5, 32'h0,        4'd0, 32'h0},
    '{1'b1, 4'd3,  4'd6,  4'd3,  4'd3, 1'b1, 4'd5,  32'h55,       4'd0, 32'h55,       4'd0, 32'h55},
    '{1'b0, 4'd0,  4'd0,  4'd3,  4'd0, 1'b0, 4'd0,  32'h0,        4'd6, 32'h55,       4'd0, 32'h0},
    '{1'b1, 4'd4,  4'd0,  4'd4,  4'd0, 1'b1, 4'd0,  32'hFF,       4'd0, 32'h0,        4'd0, 32'h0},
    '{1'b0, 4'd0,  4'd0,  4'd4,  4'd0, 1'b0, 4'd0,  32'h0,        4'd0, 32'h0,        4'd0, 32'h0},
    '{1'b1, 4'd15, 4'd15, 4'd15, 4'd3, 1'b0, 4'd0,  32'h0,        4'd0, 32'h0,        4'd6, 32'h55},
    '{1'b1, 4'd0,  4'd7,  4'd15, 4'd0, 1'b1, 4'd15, 32'hDEADBEEF, 4'd0, 32'hDEADBEEF, 4'd0, 32'h0},
    '{1'b0, 4'd0,  4'd0,  4'd15, 4'd0, 1'b0, 4'd0,  32'h0,        4'd0, 32'hDEADBEEF, 4'd7, 32'h0},
    '{1'b0, 4'd0,  4'd0,  4'd3,  4'd3, 1'b1, 4'd6,  32'h66,       4'd0, 32'h66,       4'd0, 32'h66}
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R9";
      1: return "R3";
      2: return "R8";
      3: return "R6/R2";
      4, 5, 6: return "R5";
      7, 8: return "R7";
      9, 10: return "R10";
      11: return "R4";
      12: return "R8";
      13: return "R4/R2";
      default: return "R6";
    endcase
  endfunction

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, bc_valid = 0;
  logic [3:0] iss_dst = 0, iss_tag = 0, src_a = 0, src_b = 0, bc_tag = 0;
  logic [31:0] bc_data = 0;
  logic [3:0] src_a_tag, src_b_tag;
  logic [31:0] src_a_val, src_b_val;
  int applied = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rename_status_table u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src_a(src_a), .src_b(src_b), .src_a_tag(src_a_tag), .src_a_val(src_a_val),
    .src_b_tag(src_b_tag), .src_b_val(src_b_val), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data)
  );

  task automatic check(string req, logic [3:0] eat, logic [31:0] eav, logic [3:0] ebt, logic [31:0] ebv);
    applied++;
    if (src_a_tag !== eat || src_a_val !== eav || src_b_tag !== ebt || src_b_val !== ebv) begin
      fails++;
      $display("FAIL %s: got a=%0d/%h b=%0d/%h expected a=%0d/%h b=%0d/%h",
               req, src_a_tag, src_a_val, src_b_tag, src_b_val, eat, eav, ebt, ebv);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_dst = 0; iss_tag = 0; bc_valid = 0; bc_tag = 0; bc_data = 0;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: state right after reset
    src_a = 4'd3; src_b = 4'd15; #1;
    check("R1", 4'd0, 32'h0, 4'd0, 32'h0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      iss_valid = VEC[i].iv; iss_dst = VEC[i].dst; iss_tag = VEC[i].itag;
      src_a = VEC[i].sa; src_b = VEC[i].sb;
      bc_valid = VEC[i].bv; bc_tag = VEC[i].btag; bc_data = VEC[i].bdata;
      #1;
      check(req_of(i), VEC[i].ea_tag, VEC[i].ea_val, VEC[i].eb_tag, VEC[i].eb_val);
    end
    // R1: reset in the middle of a run wipes values and tags
    @(negedge clk); idle();
    src_a = 4'd0; src_b = 4'd3;
    @(negedge clk); #1;
    check("R6", 4'd7, 32'h0, 4'd0, 32'h66);
    rst_n = 0; #1;
    check("R1", 4'd0, 32'h0, 4'd0, 32'h0);
    @(negedge clk); rst_n = 1;
    // R10: a tag-0 broadcast after reset must not touch tag-0 registers
    bc_valid = 1; bc_tag = 4'd0; bc_data = 32'hABCD; src_a = 4'd5; src_b = 4'd9; #1;
    check("R10", 4'd0, 32'h0, 4'd0, 32'h0);
    @(negedge clk); idle(); #1;
    check("R10", 4'd0, 32'h0, 4'd0, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        fails++;
        applied++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule